// File: doc/BRIEF.md
# Switching-Activity Charge Estimator

This block watches a register vector on each clock cycle that carries a valid sample. For each such sample it produces a count of the capacitive charge events that the selected logic style would draw from the supply. A side-channel experiment can use this count as a digital stand-in for supply current, in the way a probe across a series resistor would show it.

Three styles can be selected:
- **Single-rail CMOS** counts only rising bits.
- **Dual-rail (differential) CMOS** counts every toggle, because one rail of each pair always charges and the direction of the change is hidden.
- **Precharge logic** counts, in every sample, each bit that evaluates away from its precharge level.

The count for a sample is formed from all monitored bits together. It is registered with a valid strobe. An optional noisy copy adds a small signed offset taken from a 16-bit LFSR. A wrapping running total of the exact counts supports checking.

Top module: `charge_event_meter`

## Requirements
- R1: While reset is held, and until the first valid sample after reset, `est_vld`, `est_count`, `est_noisy` and `est_total` are all zero. The stored previous sample starts at zero, so the first sample after reset is compared against an all-zero vector.
- R2: With `style_sel` = 2'b00 (single-rail), or the reserved code 2'b11, the count is the number of bit positions that are 0 in the previous valid sample and 1 in the current one.
- R3: With `style_sel` = 2'b01 (dual-rail), the count is the number of bit positions that differ between the previous valid sample and the current one, in either direction.
- R4: With `style_sel` = 2'b10 (precharge), the count is the number of bit positions where the current sample differs from the parameter `PRECHG`, whatever the previous sample held.
- R5: Every valid sample replaces the stored previous sample, in all styles. A cycle with `smp_vld` low changes neither the stored sample nor the running total.
- R6: `est_vld` is high exactly in the cycle after a cycle with `smp_vld` high. In that cycle `est_count` carries that sample's count, and it holds that value until the next valid sample.
- R7: The noise source is a 16-bit Fibonacci LFSR. Its state is reset to `SEED` (default 16'hACE1). On each valid sample it steps to {s[14:0], s[15]^s[13]^s[12]^s[10]}. The offset applied to a sample is the low `OFS_W` bits of the state before that step, read as two's complement (−4..3 by default).
- R8: When `noise_en` is high for a sample, `est_noisy` equals that sample's count plus its offset, as a signed value. When `noise_en` is low, `est_noisy` equals `est_count` exactly, but the LFSR still steps.
- R9: `est_total` adds each valid sample's exact count, modulo 2^`TOT_W`. It is updated in the same cycle as `est_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_vld | input | 1 | Sample present this cycle |
| smp_bits | input | W | Monitored register vector |
| style_sel | input | 2 | Logic style: 00 single-rail, 01 dual-rail, 10 precharge, 11 as 00 |
| noise_en | input | 1 | Add the LFSR offset to the noisy output |
| est_vld | output | 1 | Estimate valid strobe |
| est_count | output | clog2(W+1) | Exact charge-event count |
| est_noisy | output | clog2(W+1)+OFS_W | Count plus signed noise offset |
| est_total | output | TOT_W | Wrapping running sum of exact counts |

## Verification
The hardest conditions to reach are those where the three styles disagree on the same bit pair. Examples are a bit that stays at 1 in precharge mode and still counts, or a falling bit that counts in dual-rail mode but not in single-rail mode. These depend on the stored previous sample, which is visible only through later counts. The bench therefore sweeps every ordered pair of values of a 6-bit configuration with a non-zero precharge pattern, in each style. That sweep reaches every previous/current combination in every bit position. A reduced total width forces the running total to wrap many times.

// File: rtl/cem_pkg.sv
package cem_pkg;

  typedef enum logic [1:0] {
    CEM_SINGLE = 2'b00,
    CEM_DUAL   = 2'b01,
    CEM_PRECH  = 2'b10,
    CEM_RSVD   = 2'b11
  } cem_style_e;

  localparam int unsigned CEM_LFSR_W = 16;

endpackage

// File: rtl/cem_event_gen.sv
module cem_event_gen
  import cem_pkg::*;
#(
  parameter int unsigned     W      = 32,
  parameter logic [W-1:0]    PRECHG = '0
) (
  input  cem_style_e         style,
  input  logic [W-1:0]       cur,
  input  logic [W-1:0]       prev,
  output logic [W-1:0]       ev
);

  // one charge-event decision per monitored bit
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (style)
        CEM_DUAL:  ev[i] = cur[i] ^ prev[i];
        CEM_PRECH: ev[i] = cur[i] ^ PRECHG[i];
        default:   ev[i] = cur[i] & ~prev[i];
      endcase
    end
  end

endmodule

// File: rtl/cem_popcount.sv
module cem_popcount #(
  parameter int unsigned W  = 32,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits,
  output logic [CW-1:0] cnt
);

  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      cnt = cnt + CW'(bits[i]);
    end
  end

endmodule

// File: rtl/cem_noise_lfsr.sv
module cem_noise_lfsr
  import cem_pkg::*;
#(
  parameter logic [CEM_LFSR_W-1:0] SEED  = 16'hACE1,
  parameter int unsigned           OFS_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  output logic signed [OFS_W-1:0]  ofs
);

  logic [CEM_LFSR_W-1:0] state_q;
  logic [CEM_LFSR_W-1:0] state_d;
  logic                  fb;

  always_comb begin
    fb      = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];
    state_d = state_q;
    if (adv) begin
      state_d = {state_q[CEM_LFSR_W-2:0], fb};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else if (adv) begin
      state_q <= state_d;
    end
  end

  assign ofs = $signed(state_q[OFS_W-1:0]);

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);  // R7

  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state_q));  // R7

endmodule

// File: rtl/charge_event_meter.sv
module charge_event_meter
  import cem_pkg::*;
#(
  parameter int unsigned     W      = 32,
  parameter logic [W-1:0]    PRECHG = '0,
  parameter int unsigned     TOT_W  = 32,
  parameter int unsigned     OFS_W  = 3,
  parameter logic [15:0]     SEED   = 16'hACE1,
  localparam int unsigned    CW     = $clog2(W + 1),
  localparam int unsigned    NW     = CW + OFS_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp_vld,
  input  logic [W-1:0]          smp_bits,
  input  logic [1:0]            style_sel,
  input  logic                  noise_en,
  output logic                  est_vld,
  output logic [CW-1:0]         est_count,
  output logic signed [NW-1:0]  est_noisy,
  output logic [TOT_W-1:0]      est_total
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_q_n = rst_pipe_q[1];

  // datapath
  cem_style_e           style;
  logic [W-1:0]         prev_q;
  logic [W-1:0]         ev;
  logic [CW-1:0]        cnt_d;
  logic signed [OFS_W-1:0] ofs;
  logic signed [NW-1:0] ofs_g;
  logic signed [NW-1:0] noisy_d;
  logic [TOT_W-1:0]     tot_d;
  logic                 vld_q;
  logic [CW-1:0]        cnt_q;
  logic signed [NW-1:0] noisy_q;
  logic [TOT_W-1:0]     tot_q;

  assign style = cem_style_e'(style_sel);

  cem_event_gen #(
    .W      (W),
    .PRECHG (PRECHG)
  ) i_event_gen (
    .style (style),
    .cur   (smp_bits),
    .prev  (prev_q),
    .ev    (ev)
  );

  cem_popcount #(
    .W  (W),
    .CW (CW)
  ) i_popcount (
    .bits (ev),
    .cnt  (cnt_d)
  );

  cem_noise_lfsr #(
    .SEED  (SEED),
    .OFS_W (OFS_W)
  ) i_noise (
    .clk   (clk),
    .rst_n (rst_q_n),
    .adv   (smp_vld),
    .ofs   (ofs)
  );

  always_comb begin
    ofs_g   = noise_en ? NW'(ofs) : '0;
    noisy_d = $signed({{(NW-CW){1'b0}}, cnt_d}) + ofs_g;
    tot_d   = tot_q + TOT_W'(cnt_d);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= smp_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      prev_q  <= '0;
      cnt_q   <= '0;
      noisy_q <= '0;
      tot_q   <= '0;
    end else if (smp_vld) begin
      prev_q  <= smp_bits;
      cnt_q   <= cnt_d;
      noisy_q <= noisy_d;
      tot_q   <= tot_d;
    end
  end

  assign est_vld   = vld_q;
  assign est_count = cnt_q;
  assign est_noisy = noisy_q;
  assign est_total = tot_q;

  // checks
  AST_VLD_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    smp_vld |=> est_vld);  // R6

  AST_NO_VLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    !smp_vld |=> !est_vld && $stable(est_count) && $stable(est_total));  // R5

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_q_n)
    est_count <= CW'(W));  // R6

  AST_DUAL_REPEAT: assert property (@(posedge clk) disable iff (!rst_q_n)
    smp_vld && style == CEM_DUAL && smp_bits == prev_q |=> est_count == '0);  // R3

  AST_PRECH_IDLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    smp_vld && style == CEM_PRECH && smp_bits == PRECHG |=> est_count == '0);  // R4

  AST_NOISE_OFF_EXACT: assert property (@(posedge clk) disable iff (!rst_q_n)
    smp_vld && !noise_en |=> est_noisy == $signed({{(NW-CW){1'b0}}, est_count}));  // R8

  AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    est_vld |-> est_total == TOT_W'($past(est_total) + TOT_W'(est_count)));  // R9

endmodule

// File: tb/test_charge_event_meter.sv
module test_charge_event_meter;

  localparam int unsigned W     = 6;
  localparam logic [W-1:0] PRE  = 6'b101100;
  localparam int unsigned TOT_W = 10;
  localparam int unsigned OFS_W = 3;
  localparam int unsigned CW    = $clog2(W + 1);
  localparam int unsigned NW    = CW + OFS_W;

  logic                  clk;
  logic                  rst_n;
  logic                  smp_vld;
  logic [W-1:0]          smp_bits;
  logic [1:0]            style_sel;
  logic                  noise_en;
  logic                  est_vld;
  logic [CW-1:0]         est_count;
  logic signed [NW-1:0]  est_noisy;
  logic [TOT_W-1:0]      est_total;

  charge_event_meter #(
    .W      (W),
    .PRECHG (PRE),
    .TOT_W  (TOT_W),
    .OFS_W  (OFS_W),
    .SEED   (16'hACE1)
  ) i_charge_event_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (smp_vld),
    .smp_bits  (smp_bits),
    .style_sel (style_sel),
    .noise_en  (noise_en),
    .est_vld   (est_vld),
    .est_count (est_count),
    .est_noisy (est_noisy),
    .est_total (est_total)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_cmp;
  int n_bad;
  bit done;

  logic [W-1:0]  m_prev;
  int            m_tot;
  int            m_last;
  logic [15:0]   m_lfsr;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ones(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(v[i]);
    return n;
  endfunction

  // one valid sample; entered and left at a falling edge
  task automatic send(input logic [W-1:0] bits, input logic [1:0] sty, input logic nen);
    int exp_c;
    int ofs;
    string req;
    case (sty)
      2'b01:   begin exp_c = ones(m_prev ^ bits);  req = "R3"; end
      2'b10:   begin exp_c = ones(bits ^ PRE);     req = "R4"; end
      default: begin exp_c = ones(~m_prev & bits); req = "R2"; end
    endcase
    ofs = int'($signed(m_lfsr[OFS_W-1:0]));
    smp_vld   = 1'b1;
    smp_bits  = bits;
    style_sel = sty;
    noise_en  = nen;
    @(negedge clk);
    m_prev = bits;
    m_tot  = (m_tot + exp_c) % (1 << TOT_W);
    m_last = exp_c;
    m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    chk("R6", "est_vld", int'(est_vld), 1);
    chk(req, "est_count", int'(est_count), exp_c);
    chk("R9", "est_total", int'(est_total), m_tot);
    if (nen) chk("R7", "est_noisy", int'(est_noisy), exp_c + ofs);
    else     chk("R8", "est_noisy", int'(est_noisy), exp_c);
  endtask

  task automatic idle(input int n);
    smp_vld  = 1'b0;
    smp_bits = '1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk("R6", "est_vld idle", int'(est_vld), 0);
      chk("R6", "est_count hold", int'(est_count), m_last);
      chk("R5", "est_total hold", int'(est_total), m_tot);
    end
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    smp_vld = 1'b0; smp_bits = '0; style_sel = 2'b00; noise_en = 1'b0;
    m_prev = '0; m_tot = 0; m_last = 0; m_lfsr = 16'hACE1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is held
    chk("R1", "est_vld in reset", int'(est_vld), 0);
    chk("R1", "est_count in reset", int'(est_count), 0);
    chk("R1", "est_noisy in reset", int'(est_noisy), 0);
    chk("R1", "est_total in reset", int'(est_total), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "est_vld after release", int'(est_vld), 0);
    chk("R1", "est_total after release", int'(est_total), 0);
    // R1: first sample compared against zero (all six bits rise)
    send(6'b111111, 2'b00, 1'b0);
    chk("R1", "first count vs zero", int'(est_count), 6);

    // exhaustive ordered pairs in each style (R2, R3, R4)
    for (int sty = 0; sty < 3; sty++) begin
      for (int a = 0; a < 64; a++) begin
        for (int b = 0; b < 64; b++) begin
          send(W'(a), 2'(sty), 1'b0);
          send(W'(b), 2'(sty), 1'b0);
        end
      end
      idle(3);
    end

    // R4: a held bit still counts in precharge mode
    send(6'b000011, 2'b10, 1'b0);
    send(6'b000011, 2'b10, 1'b0);
    chk("R4", "repeat value in precharge", int'(est_count), 5);

    // R2: reserved code behaves as single-rail
    for (int a = 0; a < 64; a++) begin
      send(W'(a * 23), 2'b11, 1'b0);
    end

    // R5: idle cycles keep the previous sample
    send(6'b010101, 2'b01, 1'b0);
    idle(4);
    send(6'b010101, 2'b01, 1'b0);
    chk("R5", "dual count after idle", int'(est_count), 0);

    // R7, R8: noise on, then mixed
    for (int a = 0; a < 400; a++) begin
      send(W'(a * 37 + 5), 2'(a % 3), 1'(a < 300 || a[0]));
    end
    idle(2);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule